// File: doc/BRIEF.md
# Multi-drop scan address selector

Several scan gateways can share one backplane test bus. This block sits in each gateway and decides whether the gateway takes part in the current test session. It follows the TAP state from TMS. At Update-IR it reads the low six bits of the instruction register. While the gateway is waiting, that value is an address: a single-device code that matches the strapped slot address, a broadcast code, or a multicast-group code that matches the gateway's 2-bit group register. Only a single-device match enables the primary TDO driver. This keeps the shared TDO line free of contention when many gateways respond at once.

Once the gateway is selected, later Update-IR values are instructions. One of them writes the group register through a 2-bit data register. Another sends the gateway back to waiting. If a gateway does not match an address, it is unselected. It ignores everything except the return-to-wait instruction and the resets. The outputs are an active-low selected flag for board buffers, the TDO output enable, and a mode code that neighbouring logic decodes. All outputs are registered.

Top module: `scan_slot_selector`

## Requirements
- R1: After `rst` (synchronous, active high), or once TMS high has walked the TAP into Test-Logic-Reset (five rising edges with TMS high always reach it), the block is waiting: `sel_n`=1, `tdo_oe`=0, `mode`=00. The outputs update one clock after the TAP enters that state.
- R2: The address compare happens only on the clock edge where the TAP is in Update-IR. It uses `ir_value[5:0]`, and `ir_value[7:6]` are ignored. Passing through the data-register path leaves a waiting block waiting. Update-IR values seen while the block is selected are instructions, not addresses.
- R3: Low bits 0x00 to 0x3A equal to `slot_addr` select the block in single mode: `sel_n`=0, `tdo_oe`=1, `mode`=01.
- R4: A slot strap of 0x3B to 0x3F is never selected as a single device. Scanning the same value acts as a broadcast or group code.
- R5: Low bits 0x3B select every waiting block in broadcast mode: `sel_n`=0, `tdo_oe`=0, `mode`=10.
- R6: Low bits 0x3C+g (g = 0..3) select the block in group mode (`sel_n`=0, `tdo_oe`=0, `mode`=11) only when its group register equals g.
- R7: Any other address makes the block unselected (`sel_n`=1, `tdo_oe`=0, `mode`=00). Later Update-IR values, including its own address, leave it unselected.
- R8: Instruction 0xC3 at Update-IR, from a selected or an unselected block, returns the block to waiting, after which a new address scan is honoured.
- R9: The group register is written only while the block is selected and the current instruction is 0x03. Capture-DR loads it, Shift-DR shifts `tdi` in LSB first, and Update-DR commits it. It clears to 00 on `rst` or in Test-Logic-Reset.
- R10: `local_rst_n` low at a clock edge returns the block to waiting at that edge. The group register is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| local_rst_n | input | 1 | Active-low local return-to-wait |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in (group register shifting) |
| ir_value | input | 8 | Instruction register contents, sampled at Update-IR |
| slot_addr | input | 6 | Strapped slot address |
| sel_n | output | 1 | Low while selected in any mode |
| tdo_oe | output | 1 | Primary TDO driver enable |
| mode | output | 2 | 00 none, 01 single, 10 broadcast, 11 group |

## Verification
The bench targets the edge between the address space and its special codes. A slot of 0x3A must still single-select. A slot of 0x3B or 0x3F must never single-select, so a decoder with an off-by-one would drive TDO during a broadcast. It checks that an unselected block ignores its own address and group-register writes: a sticky-state bug would either re-join the chain or corrupt the group. It also checks that the upper instruction bits are ignored, and that the group survives a local reset but not Test-Logic-Reset. A design that cleared the group on the wrong reset would then answer the wrong multicast code.

// File: rtl/mdsel_pkg.sv
package mdsel_pkg;

  typedef enum logic [3:0] {
    TAP_TLR, TAP_RTI,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHF_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHF_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_SINGLE, ST_BCAST, ST_GROUP, ST_UNSEL
  } sel_state_e;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_BCAST  = 2'd2,
    MODE_GROUP  = 2'd3
  } sel_mode_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      TAP_TLR:    return tms ? TAP_TLR    : TAP_RTI;
      TAP_RTI:    return tms ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_DR: return tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: return tms ? TAP_EX1_DR : TAP_SHF_DR;
      TAP_SHF_DR: return tms ? TAP_EX1_DR : TAP_SHF_DR;
      TAP_EX1_DR: return tms ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: return tms ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: return tms ? TAP_UPD_DR : TAP_SHF_DR;
      TAP_UPD_DR: return tms ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_IR: return tms ? TAP_TLR    : TAP_CAP_IR;
      TAP_CAP_IR: return tms ? TAP_EX1_IR : TAP_SHF_IR;
      TAP_SHF_IR: return tms ? TAP_EX1_IR : TAP_SHF_IR;
      TAP_EX1_IR: return tms ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: return tms ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: return tms ? TAP_UPD_IR : TAP_SHF_IR;
      default:    return tms ? TAP_SEL_DR : TAP_RTI;
    endcase
  endfunction

  function automatic sel_mode_e mode_of(input sel_state_e s);
    case (s)
      ST_SINGLE: return MODE_SINGLE;
      ST_BCAST:  return MODE_BCAST;
      ST_GROUP:  return MODE_GROUP;
      default:   return MODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tap_tracker.sv
module tap_tracker
  import mdsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge clk) begin
    if (rst) state <= TAP_TLR;
    else     state <= tap_next(state, tms);
  end

  AST_TMS_FIVE_TLR: assert property (@(posedge clk) disable iff (rst)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> state == TAP_TLR); // R1

endmodule

// File: rtl/addr_decode.sv
module addr_decode #(
  parameter int ADDR_W = 6,
  parameter int GRP_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] slot,
  input  logic [GRP_W-1:0]  grp,
  output logic              hit_single,
  output logic              hit_bcast,
  output logic              hit_group
);

  localparam int NUM_GRP  = 2 ** GRP_W;
  localparam int GRP_BASE = (2 ** ADDR_W) - NUM_GRP;
  localparam logic [ADDR_W-1:0] BCAST_CODE = ADDR_W'(GRP_BASE - 1);

  logic [NUM_GRP-1:0] grp_hit;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam logic [ADDR_W-1:0] CODE = ADDR_W'(GRP_BASE + g);
      assign grp_hit[g] = (addr == CODE) && (grp == GRP_W'(g));
    end
  endgenerate

  // A strap at or above the broadcast code can never be matched here.
  assign hit_single = (addr < BCAST_CODE) && (addr == slot);
  assign hit_bcast  = (addr == BCAST_CODE);
  assign hit_group  = |grp_hit;

endmodule

// File: rtl/group_reg.sv
module group_reg #(
  parameter int GRP_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             tdi,
  output logic [GRP_W-1:0] grp
);

  logic [GRP_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      grp   <= '0;
      shreg <= '0;
    end else if (en) begin
      if (capture)     shreg <= grp;
      else if (shift)  shreg <= {tdi, shreg[GRP_W-1:1]};
      if (update)      grp   <= shreg;
    end
  end

  AST_GRP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> grp == '0); // R9
  AST_GRP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(en && update)) |=> $stable(grp)); // R9

endmodule

// File: rtl/scan_slot_selector.sv
module scan_slot_selector
  import mdsel_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          GRP_W      = 2,
  parameter int          IR_W       = 8,
  parameter logic [7:0]  OP_GOTO_WT = 8'hC3,
  parameter logic [7:0]  OP_GRP_WR  = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              local_rst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [IR_W-1:0]   ir_value,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              sel_n,
  output logic              tdo_oe,
  output logic [1:0]        mode
);

  localparam logic [IR_W-1:0] GOTO_CODE = IR_W'(OP_GOTO_WT);
  localparam logic [IR_W-1:0] GRPW_CODE = IR_W'(OP_GRP_WR);
  localparam logic [IR_W-1:0] IDLE_INSTR = '1;

  tap_state_e       tap;
  sel_state_e       st_q, st_d;
  logic [IR_W-1:0]  instr_q, instr_d;
  logic [GRP_W-1:0] grp;
  logic             hit_single, hit_bcast, hit_group;
  logic             upd_ir, in_tlr, is_goto, active, grp_en;

  tap_tracker u_tap (
    .clk   (clk),
    .rst   (rst),
    .tms   (tms),
    .state (tap)
  );

  addr_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_dec (
    .addr       (ir_value[ADDR_W-1:0]),
    .slot       (slot_addr),
    .grp        (grp),
    .hit_single (hit_single),
    .hit_bcast  (hit_bcast),
    .hit_group  (hit_group)
  );

  assign upd_ir  = (tap == TAP_UPD_IR);
  assign in_tlr  = (tap == TAP_TLR);
  assign is_goto = (ir_value == GOTO_CODE);
  assign active  = (st_q == ST_SINGLE) || (st_q == ST_BCAST) || (st_q == ST_GROUP);
  assign grp_en  = active && (instr_q == GRPW_CODE);

  group_reg #(.GRP_W(GRP_W)) u_grp (
    .clk     (clk),
    .rst     (rst),
    .clear   (in_tlr),
    .en      (grp_en),
    .capture (tap == TAP_CAP_DR),
    .shift   (tap == TAP_SHF_DR),
    .update  (tap == TAP_UPD_DR),
    .tdi     (tdi),
    .grp     (grp)
  );

  always_comb begin
    st_d    = st_q;
    instr_d = instr_q;
    if (rst || in_tlr || !local_rst_n) begin
      st_d    = ST_WAIT;
      instr_d = IDLE_INSTR;
    end else if (upd_ir) begin
      case (st_q)
        ST_WAIT: begin
          instr_d = IDLE_INSTR;
          if (hit_single)     st_d = ST_SINGLE;
          else if (hit_bcast) st_d = ST_BCAST;
          else if (hit_group) st_d = ST_GROUP;
          else                st_d = ST_UNSEL;
        end
        ST_UNSEL: begin
          if (is_goto) st_d = ST_WAIT;
        end
        default: begin
          if (is_goto) begin
            st_d    = ST_WAIT;
            instr_d = IDLE_INSTR;
          end else begin
            instr_d = ir_value;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    st_q    <= st_d;
    instr_q <= instr_d;
    sel_n   <= !((st_d == ST_SINGLE) || (st_d == ST_BCAST) || (st_d == ST_GROUP));
    tdo_oe  <= (st_d == ST_SINGLE);
    mode    <= mode_of(st_d);
  end

  AST_TLR_TO_WAIT: assert property (@(posedge clk) disable iff (rst)
    in_tlr |=> (sel_n && !tdo_oe && mode == MODE_NONE)); // R1
  AST_LEAVE_WAIT_AT_UPDIR: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_WAIT && $past(st_q) == ST_WAIT) |-> $past(upd_ir)); // R2
  AST_OE_ONLY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tdo_oe |-> (mode == MODE_SINGLE && !sel_n)); // R3
  AST_UNSEL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_UNSEL && local_rst_n && !in_tlr && !(upd_ir && is_goto))
      |=> st_q == ST_UNSEL); // R7
  AST_GOTO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_WAIT && upd_ir && is_goto) |=> (sel_n && mode == MODE_NONE)); // R8
  AST_LOCAL_RST: assert property (@(posedge clk) disable iff (rst)
    !local_rst_n |=> (sel_n && !tdo_oe)); // R10

endmodule

// File: tb/scan_slot_selector_bench.sv
module scan_slot_selector_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       local_rst_n = 1'b1;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [7:0] ir_value = 8'hFF;
  logic [5:0] slot_addr = 6'd0;
  logic       sel_n, tdo_oe;
  logic [1:0] mode;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  scan_slot_selector u_scan_slot_selector (
    .clk(clk), .rst(rst), .local_rst_n(local_rst_n), .tms(tms), .tdi(tdi),
    .ir_value(ir_value), .slot_addr(slot_addr),
    .sel_n(sel_n), .tdo_oe(tdo_oe), .mode(mode)
  );

  typedef struct packed {
    logic [5:0] slot;
    logic [1:0] grp;
    logic [7:0] ir;
    logic       sn;
    logic       oe;
    logic [1:0] md;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{6'h05, 2'd0, 8'h05, 1'b0, 1'b1, 2'd1, 4'd3},  // R3 match
    '{6'h05, 2'd0, 8'hC5, 1'b0, 1'b1, 2'd1, 4'd2},  // R2 upper bits ignored
    '{6'h05, 2'd0, 8'h06, 1'b1, 1'b0, 2'd0, 4'd7},  // R7 mismatch
    '{6'h00, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 4'd3},  // R3 lowest
    '{6'h3A, 2'd0, 8'h3A, 1'b0, 1'b1, 2'd1, 4'd3},  // R3 highest single
    '{6'h09, 2'd0, 8'h3B, 1'b0, 1'b0, 2'd2, 4'd5},  // R5 broadcast
    '{6'h3B, 2'd0, 8'h3B, 1'b0, 1'b0, 2'd2, 4'd4},  // R4 strap 0x3B
    '{6'h09, 2'd2, 8'h3E, 1'b0, 1'b0, 2'd3, 4'd6},  // R6 group 2
    '{6'h09, 2'd2, 8'h3D, 1'b1, 1'b0, 2'd0, 4'd6},  // R6 wrong group
    '{6'h09, 2'd3, 8'h7F, 1'b0, 1'b0, 2'd3, 4'd6},  // R6 group 3, upper bits
    '{6'h09, 2'd0, 8'h3C, 1'b0, 1'b0, 2'd3, 4'd6},  // R6 group 0 default
    '{6'h3F, 2'd1, 8'h3F, 1'b1, 1'b0, 2'd0, 4'd4}   // R4 strap 0x3F
  };

  task automatic step(input logic t, input logic d);
    @(negedge clk);
    tms = t;
    tdi = d;
    @(posedge clk);
  endtask

  task automatic tap_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic scan_ir(input logic [7:0] v);
    @(negedge clk);
    ir_value = v;
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic scan_dr2(input logic b0, input logic b1);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, b0);   step(1'b1, b1);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic set_group(input logic [1:0] g);
    scan_ir(8'h3B);
    scan_ir(8'h03);
    scan_dr2(g[0], g[1]);
    scan_ir(8'hC3);
  endtask

  task automatic chk(input logic sn, input logic oe, input logic [1:0] md, input string tag);
    #5;
    checks++;
    if (sel_n !== sn || tdo_oe !== oe || mode !== md) begin
      fails++;
      $display("FAIL %s: actual sel_n=%b oe=%b mode=%0d expected sel_n=%b oe=%b mode=%0d",
               tag, sel_n, tdo_oe, mode, sn, oe, md);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=completed");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0);
    chk(1'b1, 1'b0, 2'd0, "R1 after rst");

    for (int i = 0; i < NV; i++) begin
      slot_addr = VECS[i].slot;
      tap_reset();
      if (VECS[i].grp != 2'd0) set_group(VECS[i].grp);
      scan_ir(VECS[i].ir);
      chk(VECS[i].sn, VECS[i].oe, VECS[i].md, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R1: TMS-driven reset from a selected state
    slot_addr = 6'h05;
    tap_reset();
    scan_ir(8'h05);
    chk(1'b0, 1'b1, 2'd1, "R3 select before TMS reset");
    tap_reset();
    chk(1'b1, 1'b0, 2'd0, "R1 TMS reset");

    // R7 sticky unselected, R8 return to wait
    scan_ir(8'h06);
    chk(1'b1, 1'b0, 2'd0, "R7 unselected");
    scan_ir(8'h05);
    chk(1'b1, 1'b0, 2'd0, "R7 own address ignored");
    scan_ir(8'hC3);
    chk(1'b1, 1'b0, 2'd0, "R8 goto from unselected");
    scan_ir(8'h05);
    chk(1'b0, 1'b1, 2'd1, "R8 reselect after goto");
    scan_ir(8'hC3);
    chk(1'b1, 1'b0, 2'd0, "R8 goto from selected");

    // R2: data path in wait does not compare
    @(negedge clk);
    ir_value = 8'h05;
    scan_dr2(1'b1, 1'b1);
    chk(1'b1, 1'b0, 2'd0, "R2 no compare outside Update-IR");
    scan_ir(8'h05);
    scan_ir(8'h3B);
    chk(1'b0, 1'b1, 2'd1, "R2 selected treats value as instruction");

    // R10 local reset
    @(negedge clk);
    local_rst_n = 1'b0;
    tms = 1'b0;
    @(posedge clk);
    chk(1'b1, 1'b0, 2'd0, "R10 local reset");
    @(negedge clk);
    local_rst_n = 1'b1;

    // R10 keeps group; R9 TLR clears it
    tap_reset();
    set_group(2'd1);
    @(negedge clk);
    local_rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    local_rst_n = 1'b1;
    scan_ir(8'h3D);
    chk(1'b0, 1'b0, 2'd3, "R10 group kept over local reset");
    tap_reset();
    scan_ir(8'h3D);
    chk(1'b1, 1'b0, 2'd0, "R9 group cleared by TLR");

    // R9 group write ignored while unselected
    tap_reset();
    scan_ir(8'h06);
    scan_ir(8'h03);
    scan_dr2(1'b1, 1'b1);
    scan_ir(8'hC3);
    scan_ir(8'h3F);
    chk(1'b1, 1'b0, 2'd0, "R9 write ignored when unselected");
    scan_ir(8'hC3);
    scan_ir(8'h3C);
    chk(1'b0, 1'b0, 2'd3, "R9 group still 00");

    finish_run();
  end

endmodule